// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block converts one data word per handshake into an asynchronous serial frame on a single line. Each frame has a low start bit, then between five and eight data bits with the least significant bit first. An optional slot follows the data and carries either a generated parity bit or a caller-supplied ninth bit. The frame closes with one or two high stop bits. A baud generator outside the block supplies a one-cycle bit-time tick. Every bit on the line lasts exactly one tick period.

The word, the ninth-bit value and all configuration inputs are captured in the cycle the word is accepted. They stay fixed until the frame is complete, so the configuration inputs may change at any time without damaging a frame that is already in progress. The frame starts on the first tick after acceptance. The block accepts the next word in the cycle after the final stop bit ends.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A frame begins with a start bit of value 0.
- R3: Data bits follow the start bit, least significant bit first. The count is set by `cfg_len`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_kind` selects its value: 00 makes the number of ones in data plus parity even, 01 makes it odd, 10 sends 1 and 11 sends 0.
- R5: When `cfg_extra_en` is 1 and `cfg_par_en` is 0, the value of `in_extra` follows the data. When both are 1, the parity bit is sent and `in_extra` is ignored.
- R6: A frame ends with high stop bits. There are two when `cfg_two_stop` is 1 and the data length is 6, 7 or 8. In every other case there is one, so a 5-bit frame always has exactly one.
- R7: Each bit lasts exactly one tick period. `tx_line` changes only after a clock edge at which `bit_tick` is 1.
- R8: A word is accepted at a clock edge where `in_valid` and `in_ready` are both 1. From that edge until the edge that ends the last stop bit, `in_ready` is 0 and `busy` is 1. `in_ready` is 1 again in the cycle that follows.
- R9: The data, the ninth-bit value and the configuration are sampled at acceptance. Changes to them during the frame have no effect on it.
- R10: The start bit begins at the first clock edge with `bit_tick` high that comes after the accepting edge. Until then `tx_line` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can accept a word |
| in_data | input | 8 | Data word; bits above the selected length are ignored |
| in_extra | input | 1 | Value of the optional ninth bit |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_kind | input | 2 | Parity kind: even, odd, mark, space |
| cfg_extra_en | input | 1 | Enables the ninth bit when parity is off |
| cfg_two_stop | input | 1 | Requests two stop bits (lengths 6 to 8 only) |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is pending or being sent |

## Verification
A corrupted shift register or a corrupted remaining-bit count shows up on `tx_line`. If the shift register is wrong, a data, parity or stop bit takes the wrong value, and this is visible within one tick period of that bit. If the count is wrong, the frame ends early or late, so `in_ready` changes state on the wrong tick edge. Every combination of length, parity enable, parity kind, ninth bit and stop count is swept against an expected frame that is built arithmetically. Each bit position is compared for the whole of its tick period. The configuration inputs are scrambled right after each acceptance, so a failure to hold the captured configuration appears as a wrong bit within the same frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int LEN_CODE_W = 2;

   typedef enum logic [1:0] {
      PAR_EVEN  = 2'b00,
      PAR_ODD   = 2'b01,
      PAR_MARK  = 2'b10,
      PAR_SPACE = 2'b11
   } par_kind_e;

   typedef struct packed {
      logic [LEN_CODE_W-1:0] len_code;
      logic                  par_en;
      par_kind_e             par_kind;
      logic                  extra_en;
      logic                  two_stop;
   } tx_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_WAIT = 2'b01,
      ST_SEND = 2'b10
   } tx_state_e;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
   import uart_tx_pkg::*;
#(
   parameter int MAX_W = 8,
   parameter int CNT_W = 4
) (
   input  logic [MAX_W-1:0] data,
   input  logic [CNT_W-1:0] nbits,
   input  par_kind_e        kind,
   output logic             par_bit
);

   logic [MAX_W-1:0] masked;
   logic             ones_odd;

   for (genvar g = 0; g < MAX_W; g++) begin : g_mask
      assign masked[g] = data[g] & (CNT_W'(g) < nbits);
   end

   assign ones_odd = ^masked;

   always_comb begin
      unique case (kind)
         PAR_EVEN:  par_bit = ones_odd;
         PAR_ODD:   par_bit = ~ones_odd;
         PAR_MARK:  par_bit = 1'b1;
         default:   par_bit = 1'b0;
      endcase
   end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int MAX_W      = 8,
   parameter int MIN_W      = 5,
   parameter int STOP2_MIN  = 6,
   parameter int FRAME_W    = 12,
   parameter int CNT_W      = 4
) (
   input  logic [MAX_W-1:0]   data,
   input  logic               extra,
   input  tx_cfg_t            cfg,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   frame_len
);

   logic [CNT_W-1:0] nbits;
   logic [CNT_W-1:0] opt_pos;
   logic             par_bit;
   logic             use_par;
   logic             use_extra;
   logic             has_opt;
   logic             opt_bit;
   logic             two_stop;

   assign nbits     = CNT_W'(MIN_W) + CNT_W'(cfg.len_code);
   assign use_par   = cfg.par_en;
   assign use_extra = cfg.extra_en & ~cfg.par_en;
   assign has_opt   = use_par | use_extra;
   assign opt_bit   = use_par ? par_bit : extra;
   assign two_stop  = cfg.two_stop & (nbits >= CNT_W'(STOP2_MIN));
   assign opt_pos   = nbits + CNT_W'(1);

   uart_tx_parity #(
      .MAX_W (MAX_W),
      .CNT_W (CNT_W)
   ) i_parity (
      .data    (data),
      .nbits   (nbits),
      .kind    (cfg.par_kind),
      .par_bit (par_bit)
   );

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < MAX_W; i++) begin
         if (CNT_W'(i) < nbits) begin
            frame[1+i] = data[i];
         end
      end
      if (has_opt) begin
         frame[opt_pos] = opt_bit;
      end
   end

   assign frame_len = CNT_W'(1) + nbits + CNT_W'(has_opt) + CNT_W'(1)
                      + CNT_W'(two_stop);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   frame_len,
   input  logic               advance,
   output logic               cur_bit,
   output logic               last_bit
);

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '1;
         rem_q <= '0;
      end else if (load) begin
         sh_q  <= frame;
         rem_q <= frame_len;
      end else if (advance) begin
         sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   assign cur_bit  = sh_q[0];
   assign last_bit = (rem_q == CNT_W'(1));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_tx_pkg::*;
#(
   parameter int MAX_W     = 8,
   parameter int MIN_W     = 5,
   parameter int STOP2_MIN = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [MAX_W-1:0] in_data,
   input  logic             in_extra,
   input  logic [1:0]       cfg_len,
   input  logic             cfg_par_en,
   input  logic [1:0]       cfg_par_kind,
   input  logic             cfg_extra_en,
   input  logic             cfg_two_stop,
   output logic             tx_line,
   output logic             busy
);

   localparam int FRAME_W = 1 + MAX_W + 1 + 2;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (MIN_W < 1 || MAX_W < MIN_W) begin : g_bad_width
      $error("uart_frame_tx: MIN_W must be at least 1 and not above MAX_W");
   end
   if (MAX_W - MIN_W + 1 > (1 << LEN_CODE_W)) begin : g_bad_span
      $error("uart_frame_tx: length range exceeds the length code");
   end
   if (STOP2_MIN < MIN_W) begin : g_bad_stop
      $error("uart_frame_tx: STOP2_MIN below the minimum length");
   end

   tx_state_e          state_q;
   tx_cfg_t            cfg;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   frame_len;
   logic               accept;
   logic               advance;
   logic               cur_bit;
   logic               last_bit;

   assign cfg.len_code = cfg_len;
   assign cfg.par_en   = cfg_par_en;
   assign cfg.par_kind = par_kind_e'(cfg_par_kind);
   assign cfg.extra_en = cfg_extra_en;
   assign cfg.two_stop = cfg_two_stop;

   uart_tx_framer #(
      .MAX_W     (MAX_W),
      .MIN_W     (MIN_W),
      .STOP2_MIN (STOP2_MIN),
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W)
   ) i_framer (
      .data      (in_data),
      .extra     (in_extra),
      .cfg       (cfg),
      .frame     (frame),
      .frame_len (frame_len)
   );

   assign accept  = in_valid & in_ready;
   assign advance = (state_q == ST_SEND) & bit_tick & ~last_bit;

   uart_tx_shifter #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) i_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .frame     (frame),
      .frame_len (frame_len),
      .advance   (advance),
      .cur_bit   (cur_bit),
      .last_bit  (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (in_valid) state_q <= ST_WAIT;
            ST_WAIT: if (bit_tick) state_q <= ST_SEND;
            ST_SEND: if (bit_tick && last_bit) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready = (state_q == ST_IDLE);
   assign busy     = (state_q != ST_IDLE);
   assign tx_line  = (state_q == ST_SEND) ? cur_bit : 1'b1;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic in_valid,
   input logic in_ready,
   input logic tx_line,
   input logic busy
);

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_line);  // R1

   AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_line) |-> busy);  // R2

   AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tx_line));  // R6

   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_tick) |=> $stable(tx_line));  // R7

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (busy && !in_ready));  // R8

   AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_tick) |=> busy);  // R7

endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_tick (bit_tick),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tx_line  (tx_line),
   .busy     (busy)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic       in_extra = 1'b0;
   logic [1:0] cfg_len = '0;
   logic       cfg_par_en = 1'b0;
   logic [1:0] cfg_par_kind = '0;
   logic       cfg_extra_en = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       tx_line;
   logic       busy;

   int checks = 0;
   int errors = 0;
   int tick_div = 3;
   int tick_cnt = 0;

   always #2.5 clk = ~clk;

   uart_frame_tx i_uart_frame_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_tick     (bit_tick),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .in_extra     (in_extra),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_kind (cfg_par_kind),
      .cfg_extra_en (cfg_extra_en),
      .cfg_two_stop (cfg_two_stop),
      .tx_line      (tx_line),
      .busy         (busy)
   );

   initial begin
      forever begin
         @(negedge clk);
         bit_tick = (tick_cnt == tick_div - 1);
         tick_cnt = (tick_cnt >= tick_div - 1) ? 0 : tick_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input logic ex,
                             input logic [1:0] ln, input logic pe,
                             input logic [1:0] pk, input logic xe,
                             input logic ts);
      logic  exp_bit[12];
      string exp_tag[12];
      int    nb, n, ones, cur, bad;
      logic  pb;
      nb = 5 + int'(ln);
      exp_bit[0] = 1'b0; exp_tag[0] = "R2";
      ones = 0;
      for (int i = 0; i < nb; i++) begin
         exp_bit[1+i] = d[i];
         exp_tag[1+i] = "R3";
         ones += int'(d[i]);
      end
      n = 1 + nb;
      if (pe) begin
         case (pk)
            2'b00:   pb = (ones % 2) == 1;
            2'b01:   pb = (ones % 2) == 0;
            2'b10:   pb = 1'b1;
            default: pb = 1'b0;
         endcase
         exp_bit[n] = pb; exp_tag[n] = "R4"; n++;
      end else if (xe) begin
         exp_bit[n] = ex; exp_tag[n] = "R5"; n++;
      end
      exp_bit[n] = 1'b1; exp_tag[n] = "R6"; n++;
      if (ts && nb >= 6) begin
         exp_bit[n] = 1'b1; exp_tag[n] = "R6"; n++;
      end

      @(negedge clk);
      check(in_ready === 1'b1, "R8", "ready before offer", int'(in_ready), 1);
      in_valid = 1'b1; in_data = d; in_extra = ex; cfg_len = ln;
      cfg_par_en = pe; cfg_par_kind = pk; cfg_extra_en = xe; cfg_two_stop = ts;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      // R9: scramble everything captured at acceptance
      in_data = ~d; in_extra = ~ex; cfg_len = ~ln; cfg_par_en = ~pe;
      cfg_par_kind = ~pk; cfg_extra_en = ~xe; cfg_two_stop = ~ts;
      cur = -1; bad = 0;
      while (cur < n) begin
         if (cur < 0) begin
            if (tx_line !== 1'b1) bad = 1;  // R10 wait period
         end else if (tx_line !== exp_bit[cur]) begin
            bad = 1;
         end
         if (busy !== 1'b1 || in_ready !== 1'b0) begin
            check(1'b0, "R8", "busy during frame", int'(busy), 1);
         end
         if (bit_tick) begin
            if (cur < 0)
               check(bad == 0, "R10", "line before start", int'(tx_line), 1);
            else
               check(bad == 0, exp_tag[cur], $sformatf("bit %0d held (R7 R9)", cur),
                     int'(tx_line), int'(exp_bit[cur]));
            bad = 0;
            cur++;
         end
         @(negedge clk);
      end
      check(in_ready === 1'b1 && busy === 1'b0, "R8", "ready after last stop",
            int'(in_ready), 1);
      check(tx_line === 1'b1, "R1", "idle line after frame", int'(tx_line), 1);
   endtask

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] pats[4];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
      repeat (3) @(negedge clk);
      check(tx_line === 1'b1 && in_ready === 1'b1 && busy === 1'b0, "R1",
            "reset state", int'({tx_line, in_ready, busy}), 6);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_line === 1'b1 && in_ready === 1'b1 && busy === 1'b0, "R1",
            "idle after reset", int'({tx_line, in_ready, busy}), 6);
      for (int ln = 0; ln < 4; ln++)
         for (int pe = 0; pe < 2; pe++)
            for (int pk = 0; pk < 4; pk++)
               for (int xe = 0; xe < 2; xe++)
                  for (int ts = 0; ts < 2; ts++)
                     for (int p = 0; p < 4; p++)
                        send_frame(pats[p] ^ 8'(p * 37 + ln), 1'(p + pk),
                                   2'(ln), 1'(pe), 2'(pk), 1'(xe), 1'(ts));
      tick_div = 1;
      for (int ln = 0; ln < 4; ln++)
         for (int pk = 0; pk < 4; pk++)
            send_frame(8'(ln * 53 + pk * 17), 1'(pk), 2'(ln), 1'(pk[0]),
                       2'(pk), 1'b1, 1'b1);
      tick_div = 5;
      send_frame(8'h5A, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule